// File: doc/BRIEF.md
# CAN Mode Request Handshake Controller

This block decides which operating mode a CAN controller is in: running, asleep, in configuration, or regaining bus synchronization after leaving one of the quiet modes. Software asks for sleep or configuration by writing request bits. The block answers with acknowledge bits once the request has taken effect, so each change is a four-phase handshake. A request cannot be withdrawn until its acknowledge has appeared.

All mode decisions are made on bit boundaries, marked by a one-cycle `bit_tick` strobe. Sleep is entered only when nothing is being received and every transmit buffer is empty. A pending configuration request pulls the transmit pin recessive in the cycle right after the write, without waiting for the next bit boundary. It wins over a sleep request. On entry to configuration the block gives a one-cycle reset pulse to the neighbouring control, flag and enable registers, and it allows writes to the timing and filter registers only while configuration is both requested and acknowledged. On leaving either quiet mode, the block holds the transmit pin recessive until the bus has been seen idle for a number of consecutive recessive bits. When the node is bus-off, it must see that idle run many times over.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, `sleep_req`, `init_req`, `wake_en`, `sleep_ack`, `init_ack`, `tx_force_rec`, `soft_rst` and `cfg_wr_ok` are all 0.
- R2: Sleep is entered only at a `bit_tick` where `sleep_req`=1, `init_req`=0, `rx_busy`=0 and `tx_all_empty`=1. `sleep_ack` rises in the cycle after that tick and never before a tick has seen the request.
- R3: A CPU write with the sleep field 0 leaves `sleep_req` unchanged while `sleep_ack`=0. A CPU write with the init field 0 leaves `init_req` unchanged while `init_ack`=0.
- R4: While asleep, a CPU clear of `sleep_req` takes effect in the next cycle, and `sleep_ack` falls after the next `bit_tick`.
- R5: While asleep with `wake_en`=1, `bus_activity`=1 at a `bit_tick` clears both `sleep_req` and `sleep_ack` in the following cycle. With `wake_en`=0, bus activity leaves both at 1.
- R6: `tx_force_rec` is 1 from the cycle after a CPU write sets `init_req`, which is before `init_ack` rises.
- R7: With `init_req`=1, the next `bit_tick` raises `init_ack`. `soft_rst` is 1 for exactly the first cycle of `init_ack`.
- R8: `cfg_wr_ok` is 1 only while `init_req` and `init_ack` are both 1. It falls in the cycle after the CPU clears `init_req`, while `init_ack` stays high until the next `bit_tick`.
- R9: When sleep and init are both requested, configuration mode is entered, including directly from sleep. `sleep_ack` and `init_ack` are never 1 together.
- R10: After sleep or configuration is left, `tx_force_rec` stays 1 until `RESYNC_BITS` consecutive `bit_tick` samples with `rx_recessive`=1. A sample with `rx_recessive`=0 restarts the count.
- R11: With `bus_off`=1, normal operation resumes only after `BUSOFF_SEQS` complete recessive runs.
- R12: `init_ack` and `sleep_ack` change only in the cycle after a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe marking a bit boundary |
| cpu_wr | input | 1 | CPU write strobe for the request bits |
| cpu_sleep_req | input | 1 | Written sleep request value |
| cpu_init_req | input | 1 | Written configuration request value |
| cpu_wake_en | input | 1 | Written wake-on-activity enable |
| rx_busy | input | 1 | A reception is in progress |
| tx_all_empty | input | 1 | All transmit buffers are empty |
| bus_activity | input | 1 | Bus traffic seen |
| rx_recessive | input | 1 | Current bus sample is recessive |
| bus_off | input | 1 | Node is in the bus-off error state |
| sleep_req | output | 1 | Sleep request bit as held by the block |
| init_req | output | 1 | Configuration request bit as held by the block |
| wake_en | output | 1 | Wake enable bit as held by the block |
| sleep_ack | output | 1 | Sleep mode is active |
| init_ack | output | 1 | Configuration mode is active |
| tx_force_rec | output | 1 | Force the transmit pin recessive |
| soft_rst | output | 1 | One-cycle reset pulse for the affected registers |
| cfg_wr_ok | output | 1 | Configuration registers may be written |

## Verification
Request bits and the derived `tx_force_rec` and `cfg_wr_ok` settle one clock after a CPU write. Acknowledges and the reset pulse settle one clock after the `bit_tick` that decides them. The bench drives each write and each tick as a one-cycle pulse between falling edges and samples at the falling edge that ends the pulse, which is the first cycle the new value is due. It takes a second sample one cycle later for the pulse width. Resync boundaries are checked one tick before and exactly at the final recessive sample.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

   typedef enum logic [1:0] {
      MD_RUN    = 2'd0,
      MD_SLEEP  = 2'd1,
      MD_INIT   = 2'd2,
      MD_RESYNC = 2'd3
   } mode_e;

endpackage

// File: rtl/can_mode_reqregs.sv
module can_mode_reqregs (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_wr,
   input  logic cpu_sleep_req,
   input  logic cpu_init_req,
   input  logic cpu_wake_en,
   input  logic sleep_ack,
   input  logic init_ack,
   input  logic wake_clr,
   output logic sleep_req,
   output logic init_req,
   output logic wake_en
);

   logic slp_q, ini_q, wke_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slp_q <= 1'b0;
         ini_q <= 1'b0;
         wke_q <= 1'b0;
      end else begin
         if (cpu_wr) wke_q <= cpu_wake_en;
         // sleep bit: self clear wins, clears honoured only once acknowledged
         if (wake_clr)
            slp_q <= 1'b0;
         else if (cpu_wr && (cpu_sleep_req || sleep_ack))
            slp_q <= cpu_sleep_req;
         if (cpu_wr && (cpu_init_req || init_ack))
            ini_q <= cpu_init_req;
      end
   end

   assign sleep_req = slp_q;
   assign init_req  = ini_q;
   assign wake_en   = wke_q;

   // R3: a request only falls after its acknowledge was seen
   a_r3_sleep_no_early_clear : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slp_q) |-> $past(sleep_ack));
   a_r3_init_no_early_clear : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ini_q) |-> $past(init_ack));

endmodule

// File: rtl/can_mode_resync.sv
module can_mode_resync #(
   parameter int RESYNC_BITS = 11,
   parameter int BUSOFF_SEQS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bit_tick,
   input  logic rx_recessive,
   input  logic bus_off,
   output logic done
);

   localparam int RW = $clog2(RESYNC_BITS + 1);
   localparam logic [RW-1:0] RUN_LAST = RW'(RESYNC_BITS - 1);

   logic [RW-1:0] run_q;
   logic          run_last, seq_done;

   assign run_last = (run_q == RUN_LAST);
   assign seq_done = en && bit_tick && rx_recessive && run_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (!en)
         run_q <= '0;
      else if (bit_tick) begin
         if (!rx_recessive || run_last) run_q <= '0;
         else                           run_q <= run_q + 1'b1;
      end
   end

   generate
      if (BUSOFF_SEQS > 1) begin : g_busoff_cnt
         localparam int SW = $clog2(BUSOFF_SEQS + 1);
         localparam logic [SW-1:0] SEQ_LAST = SW'(BUSOFF_SEQS - 1);
         logic [SW-1:0] seq_q;
         logic          seq_last;
         assign seq_last = (seq_q == SEQ_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               seq_q <= '0;
            else if (!en)
               seq_q <= '0;
            else if (seq_done)
               seq_q <= seq_last ? '0 : seq_q + 1'b1;
         end
         assign done = seq_done && (!bus_off || seq_last);
         // R11: while bus-off, completion needs the last run of the series
         a_r11_busoff_full_series : assert property (@(posedge clk) disable iff (!rst_n)
            (done && bus_off) |-> seq_last);
      end else begin : g_single_run
         logic unused_bus_off;
         assign unused_bus_off = bus_off;
         assign done = seq_done;
      end
   endgenerate

   // R10: completion only on a recessive sample at a bit boundary
   a_r10_done_on_recessive : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bit_tick && rx_recessive && en));

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
   import can_mode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bit_tick,
   input  logic  sleep_req,
   input  logic  init_req,
   input  logic  wake_en,
   input  logic  rx_busy,
   input  logic  tx_all_empty,
   input  logic  bus_activity,
   input  logic  resync_done,
   output mode_e mode,
   output logic  sleep_ack,
   output logic  init_ack,
   output logic  soft_rst,
   output logic  wake_clr,
   output logic  resync_en
);

   mode_e mode_q, mode_d;
   logic  soft_rst_q;
   logic  bus_quiet;

   assign bus_quiet = !rx_busy && tx_all_empty;

   always_comb begin
      mode_d   = mode_q;
      wake_clr = 1'b0;
      if (bit_tick) begin
         unique case (mode_q)
            MD_RUN: begin
               if (init_req)                    mode_d = MD_INIT;
               else if (sleep_req && bus_quiet) mode_d = MD_SLEEP;
            end
            MD_SLEEP: begin
               if (init_req)       mode_d = MD_INIT;
               else if (!sleep_req) mode_d = MD_RESYNC;
               else if (wake_en && bus_activity) begin
                  mode_d   = MD_RESYNC;
                  wake_clr = 1'b1;
               end
            end
            MD_INIT: begin
               if (!init_req) mode_d = MD_RESYNC;
            end
            MD_RESYNC: begin
               if (init_req)         mode_d = MD_INIT;
               else if (resync_done) mode_d = MD_RUN;
            end
            default: mode_d = MD_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MD_RUN;
         soft_rst_q <= 1'b0;
      end else begin
         mode_q     <= mode_d;
         soft_rst_q <= (mode_d == MD_INIT) && (mode_q != MD_INIT);
      end
   end

   assign mode      = mode_q;
   assign sleep_ack = (mode_q == MD_SLEEP);
   assign init_ack  = (mode_q == MD_INIT);
   assign soft_rst  = soft_rst_q;
   assign resync_en = (mode_q == MD_RESYNC);

   // R12: acknowledges move only after a bit boundary
   a_r12_init_ack_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(init_ack));
   a_r12_sleep_ack_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(sleep_ack));
   // R2: sleep only entered from a quiet bus
   a_r2_sleep_needs_idle : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_ack) |-> $past(bus_quiet && sleep_req && !init_req));
   // R7: reset pulse is one cycle and falls within init mode
   a_r7_pulse_in_init : assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> init_ack);
   a_r7_pulse_single : assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst);
   // R5: with wake disabled, an unchanged sleep request keeps the block asleep
   a_r5_no_wake_when_off : assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_ack && sleep_req && !wake_en && !init_req) |=> sleep_ack);

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import can_mode_pkg::*;
#(
   parameter int RESYNC_BITS = 11,
   parameter int BUSOFF_SEQS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic cpu_wr,
   input  logic cpu_sleep_req,
   input  logic cpu_init_req,
   input  logic cpu_wake_en,
   input  logic rx_busy,
   input  logic tx_all_empty,
   input  logic bus_activity,
   input  logic rx_recessive,
   input  logic bus_off,
   output logic sleep_req,
   output logic init_req,
   output logic wake_en,
   output logic sleep_ack,
   output logic init_ack,
   output logic tx_force_rec,
   output logic soft_rst,
   output logic cfg_wr_ok
);

   generate
      if (RESYNC_BITS < 2) begin : g_bad_resync_bits
         $error("can_mode_ctrl: RESYNC_BITS must be at least 2");
      end
      if (BUSOFF_SEQS < 1) begin : g_bad_busoff_seqs
         $error("can_mode_ctrl: BUSOFF_SEQS must be at least 1");
      end
   endgenerate

   mode_e mode;
   logic  wake_clr, resync_en, resync_done;

   can_mode_reqregs u_reqregs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_wr       (cpu_wr),
      .cpu_sleep_req(cpu_sleep_req),
      .cpu_init_req (cpu_init_req),
      .cpu_wake_en  (cpu_wake_en),
      .sleep_ack    (sleep_ack),
      .init_ack     (init_ack),
      .wake_clr     (wake_clr),
      .sleep_req    (sleep_req),
      .init_req     (init_req),
      .wake_en      (wake_en)
   );

   can_mode_resync #(
      .RESYNC_BITS(RESYNC_BITS),
      .BUSOFF_SEQS(BUSOFF_SEQS)
   ) u_resync (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (resync_en),
      .bit_tick    (bit_tick),
      .rx_recessive(rx_recessive),
      .bus_off     (bus_off),
      .done        (resync_done)
   );

   can_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_tick    (bit_tick),
      .sleep_req   (sleep_req),
      .init_req    (init_req),
      .wake_en     (wake_en),
      .rx_busy     (rx_busy),
      .tx_all_empty(tx_all_empty),
      .bus_activity(bus_activity),
      .resync_done (resync_done),
      .mode        (mode),
      .sleep_ack   (sleep_ack),
      .init_ack    (init_ack),
      .soft_rst    (soft_rst),
      .wake_clr    (wake_clr),
      .resync_en   (resync_en)
   );

   assign tx_force_rec = init_req || (mode != MD_RUN);
   assign cfg_wr_ok    = init_req && init_ack;

   // R6: a pending init request always keeps the pin recessive
   a_r6_init_forces_rec : assert property (@(posedge clk) disable iff (!rst_n)
      init_req |-> tx_force_rec);
   // R9: the two acknowledges are exclusive
   a_r9_acks_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(sleep_ack && init_ack));
   // R8: config writes never open outside acknowledged init
   a_r8_cfg_in_init : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_ok |-> (init_ack && tx_force_rec));

endmodule

// File: tb/can_mode_ctrl_bench.sv
module can_mode_ctrl_bench;

   localparam int RB = 11;
   localparam int BS = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0, cpu_wr = 1'b0;
   logic cpu_sleep_req = 1'b0, cpu_init_req = 1'b0, cpu_wake_en = 1'b0;
   logic rx_busy = 1'b0, tx_all_empty = 1'b1, bus_activity = 1'b0;
   logic rx_recessive = 1'b1, bus_off = 1'b0;
   logic sleep_req, init_req, wake_en, sleep_ack, init_ack;
   logic tx_force_rec, soft_rst, cfg_wr_ok;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   can_mode_ctrl #(.RESYNC_BITS(RB), .BUSOFF_SEQS(BS)) u_can_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cpu_wr(cpu_wr),
      .cpu_sleep_req(cpu_sleep_req), .cpu_init_req(cpu_init_req),
      .cpu_wake_en(cpu_wake_en), .rx_busy(rx_busy), .tx_all_empty(tx_all_empty),
      .bus_activity(bus_activity), .rx_recessive(rx_recessive), .bus_off(bus_off),
      .sleep_req(sleep_req), .init_req(init_req), .wake_en(wake_en),
      .sleep_ack(sleep_ack), .init_ack(init_ack), .tx_force_rec(tx_force_rec),
      .soft_rst(soft_rst), .cfg_wr_ok(cfg_wr_ok)
   );

   task automatic chk(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", what, act, exp);
      end
   endtask

   task automatic cpu_write(input logic s, input logic i, input logic w);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_sleep_req = s; cpu_init_req = i; cpu_wake_en = w;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic do_tick(input logic rec);
      @(negedge clk);
      bit_tick = 1'b1; rx_recessive = rec;
      @(negedge clk);
      bit_tick = 1'b0;
   endtask

   task automatic resync_plain();
      for (int k = 0; k < RB; k++) do_tick(1'b1);
   endtask

   task automatic t_reset();
      chk(sleep_req, 1'b0, "R1 sleep_req");
      chk(init_req, 1'b0, "R1 init_req");
      chk(wake_en, 1'b0, "R1 wake_en");
      chk(sleep_ack, 1'b0, "R1 sleep_ack");
      chk(init_ack, 1'b0, "R1 init_ack");
      chk(tx_force_rec, 1'b0, "R1 tx_force_rec");
      chk(soft_rst, 1'b0, "R1 soft_rst");
      chk(cfg_wr_ok, 1'b0, "R1 cfg_wr_ok");
   endtask

   task automatic t_sleep_entry_and_early_clear();
      rx_busy = 1'b1;
      cpu_write(1'b1, 1'b0, 1'b0);
      chk(sleep_ack, 1'b0, "R2 no ack before tick");
      do_tick(1'b1);
      chk(sleep_ack, 1'b0, "R2 busy receive blocks sleep");
      cpu_write(1'b0, 1'b0, 1'b0);
      chk(sleep_req, 1'b1, "R3 sleep clear ignored before ack");
      rx_busy = 1'b0; tx_all_empty = 1'b0;
      do_tick(1'b1);
      chk(sleep_ack, 1'b0, "R2 pending transmit blocks sleep");
      tx_all_empty = 1'b1;
      do_tick(1'b1);
      chk(sleep_ack, 1'b1, "R2 sleep ack after idle tick");
   endtask

   task automatic t_wake_disabled_then_cpu_exit();
      bus_activity = 1'b1;
      do_tick(1'b0);
      do_tick(1'b0);
      bus_activity = 1'b0;
      chk(sleep_ack, 1'b1, "R5 activity ignored with wake off");
      chk(sleep_req, 1'b1, "R5 request kept with wake off");
      cpu_write(1'b0, 1'b0, 1'b0);
      chk(sleep_req, 1'b0, "R4 cpu clear accepted when acked");
      chk(sleep_ack, 1'b1, "R4 ack holds until tick");
      do_tick(1'b1);
      chk(sleep_ack, 1'b0, "R4 ack falls after tick");
      chk(tx_force_rec, 1'b1, "R10 forced during resync");
      for (int k = 0; k < 5; k++) do_tick(1'b1);
      do_tick(1'b0);
      for (int k = 0; k < RB - 1; k++) do_tick(1'b1);
      chk(tx_force_rec, 1'b1, "R10 dominant restarts run");
      do_tick(1'b1);
      chk(tx_force_rec, 1'b0, "R10 released after full run");
   endtask

   task automatic t_wake_enabled();
      cpu_write(1'b1, 1'b0, 1'b1);
      chk(wake_en, 1'b1, "R5 wake enable written");
      do_tick(1'b1);
      chk(sleep_ack, 1'b1, "R5 asleep");
      bus_activity = 1'b1;
      do_tick(1'b0);
      bus_activity = 1'b0;
      chk(sleep_req, 1'b0, "R5 self clear of sleep request");
      chk(sleep_ack, 1'b0, "R5 wake drops ack");
      resync_plain();
      chk(tx_force_rec, 1'b0, "R10 resumed after wake");
   endtask

   task automatic t_init_entry();
      cpu_write(1'b0, 1'b1, 1'b0);
      chk(tx_force_rec, 1'b1, "R6 recessive right after write");
      chk(init_ack, 1'b0, "R6 before ack");
      cpu_write(1'b0, 1'b0, 1'b0);
      chk(init_req, 1'b1, "R3 init clear ignored before ack");
      do_tick(1'b1);
      chk(init_ack, 1'b1, "R7 init ack after tick");
      chk(soft_rst, 1'b1, "R7 reset pulse with ack");
      chk(cfg_wr_ok, 1'b1, "R8 config writes open");
      @(negedge clk);
      chk(soft_rst, 1'b0, "R7 pulse one cycle");
      cpu_write(1'b0, 1'b0, 1'b0);
      chk(cfg_wr_ok, 1'b0, "R8 closes on clear");
      chk(init_ack, 1'b1, "R8 ack holds until tick");
      do_tick(1'b1);
      chk(init_ack, 1'b0, "R12 ack falls at tick");
      chk(tx_force_rec, 1'b1, "R10 forced after init exit");
      resync_plain();
      chk(tx_force_rec, 1'b0, "R10 released after init");
   endtask

   task automatic t_priority();
      cpu_write(1'b1, 1'b1, 1'b0);
      do_tick(1'b1);
      chk(init_ack, 1'b1, "R9 init wins");
      chk(sleep_ack, 1'b0, "R9 no sleep ack");
      cpu_write(1'b1, 1'b0, 1'b0);
      do_tick(1'b1);
      resync_plain();
      do_tick(1'b1);
      chk(sleep_ack, 1'b1, "R2 sleep after resync");
      cpu_write(1'b1, 1'b1, 1'b0);
      do_tick(1'b1);
      chk(init_ack, 1'b1, "R9 init from sleep");
      chk(sleep_ack, 1'b0, "R9 sleep ack dropped");
   endtask

   task automatic t_busoff();
      bus_off = 1'b1;
      cpu_write(1'b1, 1'b0, 1'b0);
      do_tick(1'b1);
      chk(init_ack, 1'b0, "R11 left init");
      resync_plain();
      chk(tx_force_rec, 1'b1, "R11 one run not enough");
      for (int k = 0; k < RB * (BS - 1) - 1; k++) do_tick(1'b1);
      chk(tx_force_rec, 1'b1, "R11 one sample short");
      do_tick(1'b1);
      chk(tx_force_rec, 1'b0, "R11 released after full series");
      bus_off = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sleep_entry_and_early_clear();
      t_wake_disabled_then_cpu_exit();
      t_wake_enabled();
      t_init_entry();
      t_priority();
      t_busoff();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule